// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Controller

This block is the bus-facing half of an 8K x 8 serial memory. It watches an oversampled two-wire bus (SCL and SDA), finds START and STOP conditions, shifts bytes in most significant bit first, and answers as a slave. An open-drain enable output pulls SDA low for acknowledge bits and for zero bits of read data. The block takes a device select byte, two address bytes and data bytes. It supports byte write, page write, current-address read, random read through a repeated START, and sequential read.

Written data leaves through a load strobe to a separate page-write engine. That engine owns the row buffer and the internal write cycle. A commit pulse tells the engine to start programming. The engine reports its write cycle on `busy_i`, and during that time the block refuses its own device select, so a master can poll for completion. Read data comes from a synchronous memory port: data returns one cycle after the read enable.

Data moves in both directions at the bus's own pace, and a slave that cannot stretch the clock has no way to hold it back. For that reason the load and read interfaces have no ready signal. The engine must accept a load in the cycle it is strobed, and the memory must return data in the cycle after `mem_rd_en`. The system clock must run at least 8 times the SCL rate.

Top module: `sermem_i2c_slave`

## Requirements
- R1: The block acknowledges a device select byte whose bits 7..4 are 1010 and whose bits 3..1 equal `chip_sel[2:1:0]` in order. Bit 0 selects the direction: 1 means read, 0 means write.
- R2: On a device select mismatch the block gives no acknowledge. It then ignores every bit until the next START.
- R3: After a write select, the block acknowledges two address bytes, high byte first. Bits 15..13 of the 16-bit address are ignored.
- R4: While `wr_lock` is high, the device select and address bytes are still acknowledged. Every data byte is not acknowledged, no load strobe is issued and no commit follows.
- R5: `commit` pulses for one cycle only when a STOP arrives in the bit slot right after an acknowledged data byte. A STOP after only the address bytes gives no commit.
- R6: Each acknowledged data byte produces one `load_valid` pulse carrying the current address and the byte. Between data bytes only address bits 4..0 increment, so the address wraps inside a 32-byte row.
- R7: A random read is a write select, two address bytes, a repeated START and a read select. It returns the byte at the loaded address.
- R8: When the master acknowledges a read byte, the next byte comes from the next address. The full 13-bit address wraps from 0x1FFF to 0x0000.
- R9: After a read byte the master does not acknowledge, the block releases SDA and drives nothing until the next START.
- R10: While `busy_i` is high, the block does not acknowledge its device select.
- R11: A current-address read returns the byte at the address the previous access left behind. That address is 0 after reset.
- R12: `sda_oe` changes only while SCL is low. Read data is sent most significant bit first.
- R13: During and right after reset, `sda_oe`, `load_valid`, `commit` and `mem_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw bus clock level |
| sda_i | input | 1 | Raw bus data level |
| sda_oe | output | 1 | Pull SDA low when high |
| chip_sel | input | 3 | Expected device select bits 3..1 |
| wr_lock | input | 1 | High: refuse data bytes of writes |
| busy_i | input | 1 | Page-write engine is programming |
| load_valid | output | 1 | One-cycle strobe: a data byte for the row buffer |
| load_addr | output | 13 | Address of the loaded byte |
| load_data | output | 8 | Loaded byte |
| commit | output | 1 | One-cycle pulse: start the internal write cycle |
| mem_rd_en | output | 1 | Read request to the synchronous memory port |
| mem_rd_addr | output | 13 | Read address |
| mem_rd_data | input | 8 | Read data, valid the cycle after `mem_rd_en` |

## Verification
The hardest condition to reach from the ports is the narrow window in which a commit is legal. A STOP must land in the single bit slot after an acknowledged data byte. A polling master must then arrive while the write cycle is still running. The bench's page-engine model raises `busy_i` as soon as it sees `commit`, and a new START with a device select follows the STOP at once, so the refused device select lands inside the busy window. Separate sequences then end a write after only the address bytes, or after data bytes refused under `wr_lock`. Both must leave the commit count unchanged.

// File: rtl/sermem_pkg.sv
package sermem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVSEL,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_WDATA,
    ST_RDATA
  } sermem_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/sermem_bus_sync.sv
module sermem_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  // index STAGES-1 is the synchronized level, index STAGES the previous one
  logic [STAGES:0] scl_pipe;
  logic [STAGES:0] sda_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-1:0], scl_raw};
      sda_pipe <= {sda_pipe[STAGES-1:0], sda_raw};
    end
  end

  logic scl_now, scl_old, sda_now, sda_old;
  assign scl_now = scl_pipe[STAGES-1];
  assign scl_old = scl_pipe[STAGES];
  assign sda_now = sda_pipe[STAGES-1];
  assign sda_old = sda_pipe[STAGES];

  assign sda_lvl   = sda_now;
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_det = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/sermem_addr_ctr.sv
module sermem_addr_ctr #(
  parameter int AW = 13,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  input  logic          row_wrap,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= load_val;
    end else if (inc) begin
      if (row_wrap) q <= {q[AW-1:PW], PW'(q[PW-1:0] + 1'b1)};
      else          q <= AW'(q + 1'b1);
    end
  end
endmodule

// File: rtl/sermem_i2c_slave.sv
module sermem_i2c_slave
  import sermem_pkg::*;
#(
  parameter int AW     = 13,
  parameter int PW     = 5,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [2:0]    chip_sel,
  input  logic          wr_lock,
  input  logic          busy_i,
  output logic          load_valid,
  output logic [AW-1:0] load_addr,
  output logic [7:0]    load_data,
  output logic          commit,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [7:0]    mem_rd_data
);
  localparam int HI_W = AW - 8;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  sermem_bus_sync #(.STAGES(STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_raw  (scl_i),
    .sda_raw  (sda_i),
    .sda_lvl  (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  sermem_state_e   state;
  logic [3:0]      bitcnt;     // 0..7 data bits, 8 = byte in, 9 = ack slot clocked
  logic [7:0]      shreg;
  logic [7:0]      txreg;
  logic [HI_W-1:0] addr_hi;
  logic            data_acked;
  logic            rd_req, rd_cap;

  logic          byte_done, dev_match;
  logic          ctr_load, ctr_inc;
  logic [AW-1:0] ctr_q;

  assign byte_done = scl_fall && (bitcnt == 4'd8) && (state != ST_IDLE)
                     && !start_det && !stop_det;
  assign dev_match = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == chip_sel);
  assign ctr_load  = byte_done && (state == ST_ADDR_LO);
  assign ctr_inc   = byte_done && ((state == ST_RDATA) ||
                                   (state == ST_WDATA && !wr_lock));

  sermem_addr_ctr #(.AW(AW), .PW(PW)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ctr_load),
    .load_val({addr_hi, shreg}),
    .inc     (ctr_inc),
    .row_wrap(state == ST_WDATA),
    .q       (ctr_q)
  );

  assign mem_rd_en   = rd_req;
  assign mem_rd_addr = ctr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bitcnt     <= '0;
      shreg      <= '0;
      txreg      <= '0;
      addr_hi    <= '0;
      data_acked <= 1'b0;
      rd_req     <= 1'b0;
      rd_cap     <= 1'b0;
      sda_oe     <= 1'b0;
      load_valid <= 1'b0;
      load_addr  <= '0;
      load_data  <= '0;
      commit     <= 1'b0;
    end else begin
      load_valid <= 1'b0;
      commit     <= 1'b0;
      rd_req     <= 1'b0;
      rd_cap     <= rd_req;
      if (rd_cap) txreg <= mem_rd_data;

      if (start_det) begin
        state      <= ST_DEVSEL;
        bitcnt     <= '0;
        sda_oe     <= 1'b0;
        data_acked <= 1'b0;
      end else if (stop_det) begin
        if (state == ST_WDATA && data_acked && bitcnt <= 4'd1) commit <= 1'b1;
        state      <= ST_IDLE;
        bitcnt     <= '0;
        sda_oe     <= 1'b0;
        data_acked <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (bitcnt == 4'd8) begin
            if (state == ST_RDATA && sda_s) begin
              state  <= ST_IDLE;        // master NoAck: standby
              bitcnt <= '0;
            end else begin
              bitcnt <= 4'd9;
            end
          end
        end else if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            unique case (state)
              ST_DEVSEL: begin
                if (dev_match && !busy_i) begin
                  sda_oe <= 1'b1;
                  if (shreg[0]) begin
                    state  <= ST_RDATA;
                    rd_req <= 1'b1;
                  end else begin
                    state  <= ST_ADDR_HI;
                  end
                end else begin
                  state  <= ST_IDLE;
                  bitcnt <= '0;
                end
              end
              ST_ADDR_HI: begin
                sda_oe  <= 1'b1;
                addr_hi <= shreg[HI_W-1:0];
                state   <= ST_ADDR_LO;
              end
              ST_ADDR_LO: begin
                sda_oe <= 1'b1;
                state  <= ST_WDATA;
              end
              ST_WDATA: begin
                sda_oe     <= !wr_lock;
                data_acked <= !wr_lock;
                if (!wr_lock) begin
                  load_valid <= 1'b1;
                  load_addr  <= ctr_q;
                  load_data  <= shreg;
                end
              end
              ST_RDATA: begin
                sda_oe <= 1'b0;             // let the master answer
                rd_req <= 1'b1;             // fetch the next byte
              end
              default: ;
            endcase
          end else if (bitcnt == 4'd9) begin
            bitcnt <= '0;
            sda_oe <= (state == ST_RDATA) ? ~txreg[7] : 1'b0;
          end else if (state == ST_RDATA && bitcnt != 4'd0) begin
            sda_oe <= ~txreg[3'd7 - bitcnt[2:0]];
          end
        end
      end
    end
  end
endmodule

// File: rtl/sermem_i2c_slave_chk.sv
module sermem_i2c_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic wr_lock,
  input logic busy_i,
  input logic load_valid,
  input logic commit,
  input logic stop_det
);
  p_load_unlocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |-> !$past(wr_lock));

  p_commit_after_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(stop_det));

  p_commit_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  p_oe_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  p_busy_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && $past(busy_i)) |-> !$rose(sda_oe));
endmodule

bind sermem_i2c_slave sermem_i2c_slave_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_i     (scl_i),
  .sda_oe    (sda_oe),
  .wr_lock   (wr_lock),
  .busy_i    (busy_i),
  .load_valid(load_valid),
  .commit    (commit),
  .stop_det  (stop_det)
);

// File: tb/sermem_i2c_slave_tb.sv
module sermem_i2c_slave_tb;
  localparam int AW = 13;
  localparam int Q  = 8;   // quarter of a bus bit, in clocks

  logic clk = 1'b0;
  always #2 clk = ~clk;    // 250 MHz

  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0] chip_sel = 3'b101;
  logic wr_lock = 1'b0;
  logic busy_i;
  logic sda_oe, load_valid, commit, mem_rd_en;
  logic [AW-1:0] load_addr, mem_rd_addr;
  logic [7:0] load_data;
  logic [7:0] mem_rd_data = 8'h00;
  logic sda_bus;
  assign sda_bus = m_sda & ~sda_oe;

  sermem_i2c_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .chip_sel(chip_sel), .wr_lock(wr_lock), .busy_i(busy_i),
    .load_valid(load_valid), .load_addr(load_addr), .load_data(load_data),
    .commit(commit), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data)
  );

  int checks = 0, fails = 0;

  // ---------------- page engine and memory model ----------------
  logic [AW-1:0] st_a [64];
  logic [7:0]    st_d [64];
  int            st_n = 0;
  logic [AW-1:0] pg_a [32];
  logic [7:0]    pg_d [32];
  int            pg_n = 0;
  logic [AW-1:0] ld_a [16];
  int            ld_n = 0;
  int            commit_cnt = 0;
  int            busy_cnt = 0;
  int            r12_viol = 0;
  logic          oe_prev = 1'b0;
  assign busy_i = (busy_cnt != 0);

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ {3'b000, a[12:8]} ^ 8'h5A;
  endfunction

  function automatic logic [7:0] mem_get(input logic [AW-1:0] a);
    logic [7:0] v = pat(a);
    for (int i = 0; i < st_n; i++) if (st_a[i] == a) v = st_d[i];
    return v;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_get(mem_rd_addr);

  always @(negedge clk) begin
    if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    if (load_valid) begin
      if (pg_n < 32) begin pg_a[pg_n] = load_addr; pg_d[pg_n] = load_data; pg_n++; end
      if (ld_n < 16) begin ld_a[ld_n] = load_addr; ld_n++; end
    end
    if (commit) begin
      commit_cnt++;
      for (int i = 0; i < pg_n; i++)
        if (st_n < 64) begin st_a[st_n] = pg_a[i]; st_d[st_n] = pg_d[i]; st_n++; end
      pg_n = 0;
      busy_cnt <= 600;
    end
    // R12: output enable may move only while the bus clock is low
    if (rst_n && sda_oe !== oe_prev && m_scl) r12_viol++;
    oe_prev = sda_oe;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(); m_scl = 1'b1; wq(); m_scl = 1'b0; wq();
    end
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq();
    acked = ~sda_bus;
    m_scl = 1'b0; wq();
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; wq(); m_scl = 1'b1; wq();
      d[i] = sda_bus;
      m_scl = 1'b0; wq();
    end
    m_sda = ~mack; wq(); m_scl = 1'b1; wq(); m_scl = 1'b0; wq();
    m_sda = 1'b1;
  endtask

  // set the address with a write select and two address bytes, no STOP
  task automatic set_addr(input logic [15:0] a);
    bit k;
    bus_start();
    send_byte(8'hAA, k); chk(k, "R1 write select ack", k, 1);
    send_byte(a[15:8], k); chk(k, "R3 high address ack", k, 1);
    send_byte(a[7:0], k);  chk(k, "R3 low address ack", k, 1);
  endtask

  // device select vectors: {byte, expected ack}, chip_sel = 101
  localparam logic [8:0] DEVSEL_VEC [8] = '{
    {8'hAA, 1'b1}, {8'hAB, 1'b1}, {8'hA2, 1'b0}, {8'hBA, 1'b0},
    {8'h2A, 1'b0}, {8'hAE, 1'b0}, {8'hA8, 1'b0}, {8'hE9, 1'b0}
  };

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    bit k;
    logic [7:0] d;
    repeat (5) @(posedge clk);
    #1;
    // R13: reset state
    chk(!sda_oe && !load_valid && !commit && !mem_rd_en, "R13 outputs idle in reset",
        {sda_oe, load_valid, commit, mem_rd_en}, 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    chk(!sda_oe && !load_valid && !commit && !mem_rd_en, "R13 outputs idle after reset",
        {sda_oe, load_valid, commit, mem_rd_en}, 0);

    // R11: current-address read right after reset reads address 0
    bus_start();
    send_byte(8'hAB, k); chk(k, "R1 read select ack", k, 1);
    read_byte(1'b0, d); chk(d == pat(13'h0000), "R11 reset address 0", d, pat(13'h0000));
    bus_stop();

    // R1 / R2: device select table
    for (int i = 0; i < 8; i++) begin
      bus_start();
      send_byte(DEVSEL_VEC[i][8:1], k);
      chk(k == DEVSEL_VEC[i][0], "R1 R2 device select match", k, DEVSEL_VEC[i][0]);
      if (k && DEVSEL_VEC[i][1]) begin
        read_byte(1'b0, d);
        chk(d == pat(13'h0001), "R11 current address after read", d, pat(13'h0001));
      end
      bus_stop();
    end

    // R2: after a mismatch, the following byte is ignored
    bus_start();
    send_byte(8'hA0, k); chk(!k, "R2 mismatch nack", k, 0);
    send_byte(8'h00, k); chk(!k, "R2 standby until START", k, 0);
    bus_stop();

    // R3 R6 R5: page write across the end of a row, high bits 15..13 set
    set_addr(16'hE11E);
    send_byte(8'h11, k); chk(k, "R6 data ack", k, 1);
    send_byte(8'h22, k); chk(k, "R6 data ack", k, 1);
    send_byte(8'h33, k); chk(k, "R6 data ack", k, 1);
    send_byte(8'h44, k); chk(k, "R6 data ack", k, 1);
    bus_stop();
    chk(commit_cnt == 1, "R5 commit after data ack", commit_cnt, 1);
    chk(ld_n == 4, "R6 load count", ld_n, 4);
    chk(ld_a[0] == 13'h011E, "R3 R6 load addr 0", ld_a[0], 13'h011E);
    chk(ld_a[1] == 13'h011F, "R6 load addr 1", ld_a[1], 13'h011F);
    chk(ld_a[2] == 13'h0100, "R6 row wrap", ld_a[2], 13'h0100);
    chk(ld_a[3] == 13'h0101, "R6 load addr 3", ld_a[3], 13'h0101);

    // R10: polling during the write cycle
    bus_start();
    send_byte(8'hAA, k); chk(!k, "R10 busy nack", k, 0);
    bus_stop();
    repeat (700) @(posedge clk);
    #1;
    bus_start();
    send_byte(8'hAA, k); chk(k, "R10 ack once idle", k, 1);
    bus_stop();

    // R7 R8: random read then sequential read
    set_addr(16'h011E);
    bus_start();
    send_byte(8'hAB, k); chk(k, "R7 read select ack", k, 1);
    read_byte(1'b1, d); chk(d == 8'h11, "R7 random read", d, 8'h11);
    read_byte(1'b1, d); chk(d == 8'h22, "R8 sequential next", d, 8'h22);
    read_byte(1'b0, d); chk(d == pat(13'h0120), "R8 sequential crosses row", d, pat(13'h0120));
    bus_stop();
    set_addr(16'h0100);
    bus_start();
    send_byte(8'hAB, k);
    read_byte(1'b0, d); chk(d == 8'h33, "R6 R12 wrapped byte msb first", d, 8'h33);
    // R9: after NoAck the slave stays silent without a START
    send_byte(8'hFF, k); chk(!k && !sda_oe, "R9 standby after NoAck", k, 0);
    bus_stop();

    // R11: current-address read continues from the last access
    bus_start();
    send_byte(8'hAB, k);
    read_byte(1'b0, d); chk(d == 8'h44, "R11 current address", d, 8'h44);
    bus_stop();

    // R4: write lock
    wr_lock = 1'b1;
    set_addr(16'h0010);
    send_byte(8'hC3, k); chk(!k, "R4 data nack under lock", k, 0);
    send_byte(8'h3C, k); chk(!k, "R4 data nack under lock", k, 0);
    bus_stop();
    repeat (20) @(posedge clk);
    #1;
    chk(commit_cnt == 1 && ld_n == 4, "R4 no load no commit", commit_cnt * 16 + ld_n, 20);
    wr_lock = 1'b0;
    set_addr(16'h0010);
    bus_start();
    send_byte(8'hAB, k);
    read_byte(1'b0, d); chk(d == pat(13'h0010), "R4 memory unchanged", d, pat(13'h0010));
    bus_stop();

    // R5: STOP after the address bytes only
    set_addr(16'h0040);
    bus_stop();
    repeat (20) @(posedge clk);
    #1;
    chk(commit_cnt == 1, "R5 no commit on address-only write", commit_cnt, 1);
    bus_start();
    send_byte(8'hAB, k);
    read_byte(1'b0, d); chk(d == pat(13'h0040), "R11 dummy write sets address", d, pat(13'h0040));
    bus_stop();

    // R8: wrap of the whole array
    set_addr(16'h1FFF);
    bus_start();
    send_byte(8'hAB, k);
    read_byte(1'b1, d); chk(d == pat(13'h1FFF), "R8 last location", d, pat(13'h1FFF));
    read_byte(1'b0, d); chk(d == pat(13'h0000), "R8 wrap to 0", d, pat(13'h0000));
    bus_stop();

    chk(r12_viol == 0, "R12 sda_oe moves only with SCL low", r12_viol, 0);

    summary();
    $finish;
  end
endmodule